// File: doc/BRIEF.md
# Peripheral DMA Run Trigger and Completion Timer

This block holds the control registers of a descriptor-driven peripheral DMA engine and decides when a transfer run begins and when it is reported finished. Software writes the registers through a simple write port and reads them back through a combinational read port. A run is launched either by a software start write or by a vertical-blank pulse. A one-shot option can block further vertical-blank runs until software re-arms it. The descriptor engine itself sits outside this block. It receives a one-cycle start pulse, and when its walk is over it answers with a done pulse and the number of bytes it moved.

The block does not report completion as soon as the engine answers. It waits a number of cycles proportional to the byte count, which models the time a 2 Mbit/s serial link needs to carry those bytes. When that wait expires, the status bit falls. If the block is still enabled at that point, a one-cycle interrupt is raised.

A single controller holds the run state. It has five states:

- `ST_IDLE`: no run.
- `ST_LAUNCH`: the start pulse is being driven.
- `ST_WAIT`: waiting for the engine's done pulse.
- `ST_DELAY`: the link-time countdown.
- `ST_DONE`: the completion cycle.

It moves between them as follows:

- idle→launch on an accepted trigger.
- launch→wait unconditionally.
- wait→delay on engine done, which loads the counter with bytes × cycles-per-byte.
- delay→done when the counter reads zero; otherwise the counter decrements.
- done→idle unconditionally.

The status bit reads 1 in every state but idle.

Register selects, used for both `wr_sel` and `rd_sel`:

| Select | Register |
|---|---|
| 0 | enable |
| 1 | start/status |
| 2 | trigger select |
| 3 | system word |
| 4 | one-shot clear |
| 5 | protection word |
| 6 | mode word |
| 7 | lockout flag (read only, bit 0) |

Top module: `dma_trig_ctrl`

## Requirements
- R1: After reset the registers read as follows: enable 0, status 0, trigger select 0, system word 0x3A980000, one-shot clear 0, protection word 0x00007F00, mode word 0x00000001, lockout 0. Both `eng_start` and `irq` are low.
- R2: A write to the enable register (select 0) keeps only bit 0 of the data. The enable register reads back as that bit, with all other bits zero.
- R3: A write to select 1 with bit 0 set starts a run only while enable is 1. `eng_start` is high for exactly the one cycle after the write edge, and status (select 1, bit 0) reads 1 from that edge. With enable at 0, or with bit 0 clear in the data, nothing starts.
- R4: A `vblank` pulse while enable is 1 and trigger-select bit 0 is 1 starts a run, provided the lockout is clear. A `vblank` pulse while enable is 0 has no effect.
- R5: When a run is started by `vblank` while system-word bit 12 is 1, the lockout flag is set. While the lockout is set, later `vblank` pulses start nothing.
- R6: The lockout is cleared by a write to the one-shot clear register (select 4) with bit 0 set, and a write there with bit 0 clear leaves it set. It is also cleared by a `vblank` pulse while enable is 1 and trigger-select bit 0 is 0; such a pulse starts no run.
- R7: Suppose `eng_done` is sampled high with byte count N at clock edge E. Then `irq` is high for one cycle after edge E + N·CPB + 1, and status reads 0 after edge E + N·CPB + 2. Here CPB = CLK_HZ / (LINK_BPS/8).
- R8: If enable is 0 when the delay expires, status still falls at the same edge and `irq` stays low.
- R9: A software start write or a triggering `vblank` that arrives while a run is in progress starts nothing. The current run still completes once, with its normal timing.
- R10: The delay counter holds the largest byte count times CPB without wrapping, so the completion timing of R7 holds for N = 2^BYTE_W − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | 32 | Read data (combinational) |
| vblank | input | 1 | Vertical-blank pulse, one cycle |
| eng_start | output | 1 | Start pulse to the descriptor engine |
| eng_done | input | 1 | Engine finished its walk |
| eng_bytes | input | BYTE_W | Bytes moved, valid with eng_done |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The completion timer is swept over every byte count of a small configuration (6-bit count, 3 cycles per byte). Each measured interrupt cycle and status-fall cycle is compared with N·3+1 and N·3+2. This exposes off-by-one errors, a wrong product, and counter wrap at the maximum count.

The trigger paths are exercised with distinct patterns: software start with enable on and off, a start write with bit 0 clear, vertical blank under both trigger-select values and with enable off, and vertical blank with the one-shot bit set. Each pattern separates one gating term from the others.

Starts injected mid-run, and an enable cleared mid-run, show whether a run can be re-entered and whether the interrupt is gated by the enable value at expiry.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    typedef enum logic [2:0] {
        SEL_EN   = 3'd0,
        SEL_GO   = 3'd1,
        SEL_TRIG = 3'd2,
        SEL_SYS  = 3'd3,
        SEL_OCLR = 3'd4,
        SEL_PROT = 3'd5,
        SEL_MODE = 3'd6,
        SEL_LOCK = 3'd7
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LAUNCH = 3'd1,
        ST_WAIT   = 3'd2,
        ST_DELAY  = 3'd3,
        ST_DONE   = 3'd4
    } run_state_e;

    localparam logic [31:0] RST_SYS  = 32'h3A98_0000;
    localparam logic [31:0] RST_PROT = 32'h0000_7F00;
    localparam logic [31:0] RST_MODE = 32'h0000_0001;
    localparam int          ONESHOT_BIT = 12;

endpackage

// File: rtl/dtc_regfile.sv
module dtc_regfile
    import dtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_sel,
    input  logic        busy,
    input  logic        lock_set,
    input  logic        lock_clr_vb,
    output logic        en_q,
    output logic        trig0,
    output logic        oneshot,
    output logic        lock_q,
    output logic        go_req,
    output logic [31:0] rd_data
);

    reg_sel_e    wsel;
    reg_sel_e    rsel;
    logic [31:0] trig_q;
    logic [31:0] sys_q;
    logic [31:0] oclr_q;
    logic [31:0] prot_q;
    logic [31:0] mode_q;
    logic        oclr_hit;

    assign wsel     = reg_sel_e'(wr_sel);
    assign rsel     = reg_sel_e'(rd_sel);
    assign go_req   = wr_en && (wsel == SEL_GO) && wr_data[0];
    assign oclr_hit = wr_en && (wsel == SEL_OCLR) && wr_data[0];
    assign trig0    = trig_q[0];
    assign oneshot  = sys_q[ONESHOT_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            trig_q <= '0;
            sys_q  <= RST_SYS;
            oclr_q <= '0;
            prot_q <= RST_PROT;
            mode_q <= RST_MODE;
        end else if (wr_en) begin
            case (wsel)
                SEL_EN:   en_q   <= wr_data[0];
                SEL_TRIG: trig_q <= wr_data;
                SEL_SYS:  sys_q  <= wr_data;
                SEL_OCLR: oclr_q <= wr_data;
                SEL_PROT: prot_q <= wr_data;
                SEL_MODE: mode_q <= wr_data;
                default:  ;
            endcase
        end
    end

    // Lockout flag: a clear from either source wins over a set in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (oclr_hit || lock_clr_vb) begin
            lock_q <= 1'b0;
        end else if (lock_set) begin
            lock_q <= 1'b1;
        end
    end

    always_comb begin
        unique case (rsel)
            SEL_EN:   rd_data = {31'b0, en_q};
            SEL_GO:   rd_data = {31'b0, busy};
            SEL_TRIG: rd_data = trig_q;
            SEL_SYS:  rd_data = sys_q;
            SEL_OCLR: rd_data = oclr_q;
            SEL_PROT: rd_data = prot_q;
            SEL_MODE: rd_data = mode_q;
            SEL_LOCK: rd_data = {31'b0, lock_q};
        endcase
    end

    // R2: enable changes only through a write to its own select
    a_r2_enable_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wsel == SEL_EN)) |=> $stable(en_q));

    // R5: the lockout rises only when the one-shot bit was set
    a_r5_lock_needs_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(oneshot));

endmodule

// File: rtl/dtc_trigger.sv
module dtc_trigger (
    input  logic vblank,
    input  logic en_q,
    input  logic trig0,
    input  logic oneshot,
    input  logic lock_q,
    input  logic idle,
    input  logic go_req,
    output logic launch,
    output logic lock_set,
    output logic lock_clr_vb
);

    logic vb_live;
    logic vb_run;
    logic sw_run;

    assign vb_live     = vblank && en_q;
    assign vb_run      = vb_live && trig0 && !lock_q && idle;
    assign sw_run      = go_req && en_q && idle;
    assign launch      = vb_run || sw_run;
    assign lock_set    = vb_run && oneshot;
    assign lock_clr_vb = vb_live && !trig0;

endmodule

// File: rtl/dtc_delay.sv
module dtc_delay #(
    parameter int BYTE_W = 12,
    parameter int CPB    = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              tick,
    input  logic [BYTE_W-1:0] bytes,
    output logic              expired
);

    localparam int MAX_BYTES = (1 << BYTE_W) - 1;
    localparam int CNT_W     = $clog2(MAX_BYTES * CPB + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    assign load_val = CNT_W'(bytes) * CNT_W'(CPB);
    assign expired  = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R10: the count moves only on a load or a tick
    a_r10_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/dma_trig_ctrl.sv
module dma_trig_ctrl
    import dtc_pkg::*;
#(
    parameter int BYTE_W   = 12,
    parameter int CLK_HZ   = 250_000_000,
    parameter int LINK_BPS = 2_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_sel,
    output logic [31:0]       rd_data,
    input  logic              vblank,
    output logic              eng_start,
    input  logic              eng_done,
    input  logic [BYTE_W-1:0] eng_bytes,
    output logic              irq
);

    localparam int CPB_RAW = CLK_HZ / (LINK_BPS / 8);
    localparam int CPB     = (CPB_RAW < 1) ? 1 : CPB_RAW;

    run_state_e state_q;
    run_state_e state_d;

    logic en_q, trig0, oneshot, lock_q, go_req;
    logic launch, lock_set, lock_clr_vb;
    logic busy, idle, load, tick, expired;

    dtc_regfile u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .rd_sel      (rd_sel),
        .busy        (busy),
        .lock_set    (lock_set),
        .lock_clr_vb (lock_clr_vb),
        .en_q        (en_q),
        .trig0       (trig0),
        .oneshot     (oneshot),
        .lock_q      (lock_q),
        .go_req      (go_req),
        .rd_data     (rd_data)
    );

    dtc_trigger u_trig (
        .vblank      (vblank),
        .en_q        (en_q),
        .trig0       (trig0),
        .oneshot     (oneshot),
        .lock_q      (lock_q),
        .idle        (idle),
        .go_req      (go_req),
        .launch      (launch),
        .lock_set    (lock_set),
        .lock_clr_vb (lock_clr_vb)
    );

    dtc_delay #(.BYTE_W(BYTE_W), .CPB(CPB)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .tick    (tick),
        .bytes   (eng_bytes),
        .expired (expired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (launch)   state_d = ST_LAUNCH;
            ST_LAUNCH:               state_d = ST_WAIT;
            ST_WAIT:   if (eng_done) state_d = ST_DELAY;
            ST_DELAY:  if (expired)  state_d = ST_DONE;
            ST_DONE:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        idle      = (state_q == ST_IDLE);
        busy      = !idle;
        eng_start = (state_q == ST_LAUNCH);
        load      = (state_q == ST_WAIT) && eng_done;
        tick      = (state_q == ST_DELAY) && !expired;
        irq       = (state_q == ST_DONE) && en_q;
    end

    // R3: a start pulse is only issued after enable was set
    a_r3_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $past(en_q));

    // R7: interrupt lasts one cycle and the run is idle afterwards
    a_r7_irq_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> (!irq && state_q == ST_IDLE));

    // R9: no start pulse follows a busy cycle
    a_r9_busy_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !eng_start);

endmodule

// File: tb/test_dma_trig_ctrl.sv
`timescale 1ns/1ps
module test_dma_trig_ctrl;
    import dtc_pkg::*;

    localparam int BW  = 6;
    localparam int CPB = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [31:0]   wr_data = '0;
    logic [2:0]    rd_sel = '0;
    logic          vblank = 1'b0;
    logic          eng_done = 1'b0;
    logic [BW-1:0] eng_bytes = '0;
    wire  [31:0]   rd_data;
    wire           eng_start;
    wire           irq;

    int total = 0;
    int bad = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    dma_trig_ctrl #(.BYTE_W(BW), .CLK_HZ(750_000), .LINK_BPS(2_000_000)) i_dma_trig_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .vblank(vblank), .eng_start(eng_start),
        .eng_done(eng_done), .eng_bytes(eng_bytes), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input reg_sel_e s, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic vb();
        @(negedge clk); vblank = 1'b1;
        @(negedge clk); vblank = 1'b0;
    endtask

    task automatic rd(input reg_sel_e s, output logic [31:0] v);
        rd_sel = s; #1 v = rd_data;
    endtask

    task automatic engine_done(input int n);
        @(negedge clk); eng_bytes = BW'(n); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    task automatic wait_end(input int n, input bit exp_irq, input string req);
        int irq_k = -1;
        int busy_k = -1;
        rd_sel = SEL_GO;
        for (int k = 1; k <= n * CPB + 20 && busy_k < 0; k++) begin
            @(negedge clk);
            if (irq && irq_k < 0) irq_k = k;
            if (rd_data[0] == 1'b0) busy_k = k;
        end
        chk(req, irq_k, exp_irq ? n * CPB + 1 : -1);
        chk(req, busy_k, n * CPB + 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(SEL_EN, v);   chk("R1", v, 32'h0);
        rd(SEL_GO, v);   chk("R1", v, 32'h0);
        rd(SEL_TRIG, v); chk("R1", v, 32'h0);
        rd(SEL_SYS, v);  chk("R1", v, 32'h3A98_0000);
        rd(SEL_OCLR, v); chk("R1", v, 32'h0);
        rd(SEL_PROT, v); chk("R1", v, 32'h0000_7F00);
        rd(SEL_MODE, v); chk("R1", v, 32'h1);
        rd(SEL_LOCK, v); chk("R1", v, 32'h0);
        chk("R1", {30'b0, eng_start, irq}, 32'h0);

        // R2 only bit 0 of enable kept
        wr(SEL_EN, 32'hFFFF_FFFE); rd(SEL_EN, v); chk("R2", v, 32'h0);
        wr(SEL_EN, 32'h0000_0003); rd(SEL_EN, v); chk("R2", v, 32'h1);

        // R3 software start gating
        wr(SEL_EN, 0);
        wr(SEL_GO, 1); chk("R3", eng_start, 0); rd(SEL_GO, v); chk("R3", v, 0);
        wr(SEL_EN, 1);
        wr(SEL_GO, 2); chk("R3", eng_start, 0); rd(SEL_GO, v); chk("R3", v, 0);
        wr(SEL_GO, 1); chk("R3", eng_start, 1); rd(SEL_GO, v); chk("R3", v, 1);
        @(negedge clk); chk("R3", eng_start, 0);
        engine_done(4); wait_end(4, 1'b1, "R7");

        // R7 / R10 sweep of every byte count
        for (int n = 0; n < (1 << BW); n++) begin
            wr(SEL_GO, 1); chk("R3", eng_start, 1);
            engine_done(n);
            wait_end(n, 1'b1, (n == (1 << BW) - 1) ? "R10" : "R7");
        end

        // R8 enable dropped before expiry: no interrupt
        wr(SEL_GO, 1); wr(SEL_EN, 0);
        engine_done(5); wait_end(5, 1'b0, "R8");
        wr(SEL_EN, 1);

        // R9 starts ignored while a run is in progress
        wr(SEL_TRIG, 1);
        wr(SEL_GO, 1); chk("R9", eng_start, 1);
        wr(SEL_GO, 1); chk("R9", eng_start, 0);
        vb();          chk("R9", eng_start, 0);
        engine_done(6); wait_end(6, 1'b1, "R9");

        // R4 vblank trigger
        wr(SEL_EN, 0); vb(); chk("R4", eng_start, 0); rd(SEL_GO, v); chk("R4", v, 0);
        wr(SEL_EN, 1); vb(); chk("R4", eng_start, 1);
        engine_done(2); wait_end(2, 1'b1, "R4");
        rd(SEL_LOCK, v); chk("R4", v, 0);

        // R5 one-shot lockout
        wr(SEL_SYS, 32'h3A98_1000);
        vb(); chk("R5", eng_start, 1);
        engine_done(1); wait_end(1, 1'b1, "R5");
        rd(SEL_LOCK, v); chk("R5", v, 1);
        vb(); chk("R5", eng_start, 0); rd(SEL_GO, v); chk("R5", v, 0);

        // R6 lockout clearing
        wr(SEL_OCLR, 0); rd(SEL_LOCK, v); chk("R6", v, 1);
        wr(SEL_OCLR, 1); rd(SEL_LOCK, v); chk("R6", v, 0);
        vb(); chk("R6", eng_start, 1);
        engine_done(1); wait_end(1, 1'b1, "R6");
        rd(SEL_LOCK, v); chk("R6", v, 1);
        wr(SEL_TRIG, 0);
        vb(); chk("R6", eng_start, 0);
        rd(SEL_LOCK, v); chk("R6", v, 0);

        ended = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule